// File: doc/BRIEF.md
# Flag-Conditioned Register Swap Unit

This block is a compact execution slice that holds four 32-bit floating-point working registers together with a five-bit status word made of zero, negative, test, latched-underflow and latched-overflow flags. It accepts one 32-bit instruction word per cycle under an instruction-valid strobe. It checks the word against a fixed swap opcode and tests a 4-bit condition field against the current status flags. When the condition holds, it exchanges the two registers named by the word within that single clock edge. The status word is never altered by the swap.

A side write port lets surrounding logic or a test harness preset any register or the status word. It acts only in cycles where no instruction is presented. The register contents and flags are visible on output ports at all times. A one-cycle `done` pulse marks each accepted instruction, and a one-cycle `swapped` pulse marks those whose condition held.

Top module: `swap_unit`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears all four registers, all flags, `done` and `swapped` to zero.
- R2: An instruction is accepted when `instr_valid` is high, `instr[31:16]` equals 16'h7B00 and `instr[15:8]` is zero. Its condition is `instr[7:4]`, its first register index is `instr[1:0]` and its second register index is `instr[3:2]`. `done` is high for exactly the cycle after each accepting edge.
- R3: Codes 0000 (ZF=0), 0001 (ZF=1), 0010 (ZF=0 and NF=0), 0011 (NF=0), 0100 (NF=1) and 0101 (ZF=1 or NF=1) cause a swap only when their flag test holds.
- R4: Codes 1010 (TF=1), 1011 (TF=0), 1100 (LUF=1) and 1101 (LVF=1) cause a swap only when their flag test holds.
- R5: Codes 1110 and 1111 always cause a swap.
- R6: Codes 0110 through 1001 never cause a swap.
- R7: When the condition holds, each of the two selected registers takes the other's previous value at the accepting edge, and `swapped` is high in the following cycle. If both indices name the same register, all registers stay unchanged.
- R8: No instruction, of any condition code, changes any flag.
- R9: A word with `instr_valid` high but a mismatching upper half or nonzero `instr[15:8]` changes no register or flag and produces no `done` or `swapped` pulse.
- R10: With `wr_en` high and `instr_valid` low, `wr_sel` 0 to 3 loads `wr_data` into that register. `wr_sel` 4 loads the flags from `wr_data[4:0]` = {LVF, LUF, TF, NF, ZF}. `wr_sel` 5 to 7 changes nothing. The write port is ignored whenever `instr_valid` is high.
- R11: `done` and `swapped` are low in every cycle that does not follow an accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| wr_en | input | 1 | Preset write strobe |
| wr_sel | input | 3 | Preset target: 0-3 register, 4 flags |
| wr_data | input | 32 | Preset data |
| regs_o | output | 128 | Register contents, register i in bits [32i+31:32i] |
| flags_o | output | 5 | Flags {LVF, LUF, TF, NF, ZF} |
| done | output | 1 | Pulse after an accepted instruction |
| swapped | output | 1 | Pulse after an accepted instruction whose condition held |

## Verification
The hardest situation to reach from the ports is each condition code meeting the exact flag combination that separates its true and false outcomes, such as greater-than with NF clear but ZF set, or the latched tests with only one latch bit raised. The stimulus reaches every such pairing by presetting all 32 flag patterns through the write port and issuing every one of the 16 condition codes against each pattern. Random instruction streams with occasional malformed words, equal register indices and write attempts during instructions then cover the interleavings.

// File: rtl/swap_pkg.sv
// Package: shared types of the conditional swap unit.
// Assumes the flag word layout {LVF, LUF, TF, NF, ZF} from bit 4 down to bit 0.
package swap_pkg;

    typedef struct packed {
        logic lvf;
        logic luf;
        logic tf;
        logic nf;
        logic zf;
    } flags_t;

    typedef enum logic [3:0] {
        CC_NZ    = 4'b0000,
        CC_Z     = 4'b0001,
        CC_POS   = 4'b0010,
        CC_NNEG  = 4'b0011,
        CC_NEG   = 4'b0100,
        CC_NPOS  = 4'b0101,
        CC_TSET  = 4'b1010,
        CC_TCLR  = 4'b1011,
        CC_UNDR  = 4'b1100,
        CC_OVER  = 4'b1101,
        CC_ALW   = 4'b1110,
        CC_ALW2  = 4'b1111
    } cond_e;

endpackage

// File: rtl/swap_decode.sv
// Module: swap_decode
// Recognises the conditional swap opcode and splits out its fields.
// Assumes the fixed upper pattern 16'h7B00, a zero byte in [15:8],
// the condition in [7:4], the second index in [3:2] and the first in [1:0].
module swap_decode #(
    parameter int IW = 32,
    parameter int SW = 2
) (
    input  logic          instr_valid,
    input  logic [IW-1:0] instr,
    output logic          accept,
    output logic [3:0]    cond,
    output logic [SW-1:0] sel_a,
    output logic [SW-1:0] sel_b
);
    localparam logic [15:0] OPC_HI = 16'h7B00;
    localparam logic [7:0]  OPC_MID = 8'h00;

    // Field extraction and opcode match.
    always_comb begin
        cond   = instr[7:4];
        sel_b  = instr[2 +: SW];
        sel_a  = instr[0 +: SW];
        accept = instr_valid && (instr[31:16] == OPC_HI) && (instr[15:8] == OPC_MID);
    end
endmodule

// File: rtl/swap_cond_eval.sv
// Module: swap_cond_eval
// Evaluates a 4-bit condition code against the current flags.
// Assumes unused codes (0110..1001) evaluate false.
module swap_cond_eval
    import swap_pkg::*;
(
    input  logic [3:0] cond,
    input  flags_t     flags,
    output logic       take
);
    // Condition truth table.
    always_comb begin
        case (cond)
            CC_NZ:   take = !flags.zf;
            CC_Z:    take =  flags.zf;
            CC_POS:  take = !flags.zf && !flags.nf;
            CC_NNEG: take = !flags.nf;
            CC_NEG:  take =  flags.nf;
            CC_NPOS: take =  flags.zf || flags.nf;
            CC_TSET: take =  flags.tf;
            CC_TCLR: take = !flags.tf;
            CC_UNDR: take =  flags.luf;
            CC_OVER: take =  flags.lvf;
            CC_ALW:  take = 1'b1;
            CC_ALW2: take = 1'b1;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/swap_regfile.sv
// Module: swap_regfile
// Holds the working registers and the flag word; performs the exchange
// or a preset load. Assumes swap and load are never requested together
// (the top gates loads off during instructions).
module swap_regfile
    import swap_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 4,
    parameter int SW   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     swap_en,
    input  logic [SW-1:0]            sel_a,
    input  logic [SW-1:0]            sel_b,
    input  logic                     load_reg_en,
    input  logic                     load_flag_en,
    input  logic [SW-1:0]            load_idx,
    input  logic [DW-1:0]            load_data,
    output logic [NREG-1:0][DW-1:0]  regs,
    output flags_t                   flags
);
    // Register file update: exchange has priority, then preset load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (swap_en && (sel_a != sel_b)) begin
            regs[sel_a] <= regs[sel_b];
            regs[sel_b] <= regs[sel_a];
        end else if (load_reg_en) begin
            regs[load_idx] <= load_data;
        end
    end

    // Flag word: only the preset port writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (load_flag_en) begin
            flags <= flags_t'(load_data[4:0]);
        end
    end

    AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && sel_a != sel_b) |=> (regs[$past(sel_a)] == $past(regs[sel_b])
                                         && regs[$past(sel_b)] == $past(regs[sel_a]))); // R7
    AST_SWAP_SAME_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && sel_a == sel_b) |=> $stable(regs)); // R7
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_flag_en |=> $stable(flags)); // R8
endmodule

// File: rtl/swap_unit.sv
// Module: swap_unit (top)
// Conditional register swap execution slice: decode, condition test,
// register-file update and one-cycle completion pulses.
// Assumes a synchronous active-low reset and that the preset port is only
// honoured in cycles with no instruction presented.
module swap_unit
    import swap_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 4,
    parameter int IW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [IW-1:0]        instr,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [DW-1:0]        wr_data,
    output logic [NREG*DW-1:0]   regs_o,
    output logic [4:0]           flags_o,
    output logic                 done,
    output logic                 swapped
);
    localparam int SW = $clog2(NREG);
    localparam logic [2:0] FLAG_SEL = 3'(NREG);

    logic                     accept;
    logic [3:0]               cond;
    logic [SW-1:0]            sel_a;
    logic [SW-1:0]            sel_b;
    logic                     take;
    logic                     swap_en;
    logic                     load_reg_en;
    logic                     load_flag_en;
    logic [NREG-1:0][DW-1:0]  regs;
    flags_t                   flags;
    logic                     done_q;
    logic                     swapped_q;

    swap_decode #(.IW(IW), .SW(SW)) u_decode (
        .instr_valid (instr_valid),
        .instr       (instr),
        .accept      (accept),
        .cond        (cond),
        .sel_a       (sel_a),
        .sel_b       (sel_b)
    );

    swap_cond_eval u_cond (
        .cond  (cond),
        .flags (flags),
        .take  (take)
    );

    // Gate the exchange on acceptance and the preset port on an idle instruction slot.
    always_comb begin
        swap_en      = accept && take;
        load_reg_en  = wr_en && !instr_valid && (wr_sel < FLAG_SEL);
        load_flag_en = wr_en && !instr_valid && (wr_sel == FLAG_SEL);
    end

    swap_regfile #(.DW(DW), .NREG(NREG), .SW(SW)) u_rf (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_en      (swap_en),
        .sel_a        (sel_a),
        .sel_b        (sel_b),
        .load_reg_en  (load_reg_en),
        .load_flag_en (load_flag_en),
        .load_idx     (wr_sel[SW-1:0]),
        .load_data    (wr_data),
        .regs         (regs),
        .flags        (flags)
    );

    // Completion pulses, one cycle after the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            swapped_q <= 1'b0;
        end else begin
            done_q    <= accept;
            swapped_q <= swap_en;
        end
    end

    // Output mapping.
    always_comb begin
        regs_o  = regs;
        flags_o = flags;
        done    = done_q;
        swapped = swapped_q;
    end

    AST_SWAP_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        swapped_q |-> done_q); // R7
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!done_q && !swapped_q)); // R11
    AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cond >= 4'd6 && cond <= 4'd9) |=> !swapped_q); // R6
    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cond[3:1] == 3'b111) |=> swapped_q); // R5
    AST_IGNORED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !wr_en) |=> ($stable(regs_o) && $stable(flags_o))); // R9
endmodule

// File: tb/test_swap_unit.sv
// Bench for swap_unit: directed sweeps of every condition against every
// flag pattern, plus seeded random streams, checked against a bench model.
module test_swap_unit;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [31:0]   wr_data = '0;
    logic [127:0]  regs_o;
    logic [4:0]    flags_o;
    logic          done;
    logic          swapped;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] m_regs [4];
    logic [4:0]  m_flags;

    always #2 clk = ~clk;

    swap_unit i_swap_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .regs_o(regs_o), .flags_o(flags_o), .done(done), .swapped(swapped)
    );

    function automatic logic cond_true(input logic [3:0] c, input logic [4:0] f);
        logic z, n, t, lu, lv;
        z = f[0]; n = f[1]; t = f[2]; lu = f[3]; lv = f[4];
        case (c)
            4'd0:  return !z;
            4'd1:  return z;
            4'd2:  return !z && !n;
            4'd3:  return !n;
            4'd4:  return n;
            4'd5:  return z || n;
            4'd10: return t;
            4'd11: return !t;
            4'd12: return lu;
            4'd13: return lv;
            4'd14, 4'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string cond_req(input logic [3:0] c);
        if (c <= 4'd5) return "R3";
        if (c >= 4'd10 && c <= 4'd13) return "R4";
        if (c >= 4'd14) return "R5";
        return "R6";
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [1:0] b, input logic [1:0] a);
        return {16'h7B00, 8'h00, c, b, a};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus, model update and output comparison.
    task automatic step(input logic v, input logic [31:0] ins, input logic we,
                        input logic [2:0] ws, input logic [31:0] wd, input string req);
        logic legal, exp_done, exp_sw;
        logic [127:0] exp_regs;
        logic [31:0] tmp;
        @(negedge clk);
        instr_valid = v; instr = ins; wr_en = we; wr_sel = ws; wr_data = wd;
        legal = (ins[31:16] == 16'h7B00) && (ins[15:8] == 8'h00);
        exp_done = v && legal;
        exp_sw = exp_done && cond_true(ins[7:4], m_flags);
        if (exp_sw) begin
            tmp = m_regs[ins[1:0]];
            m_regs[ins[1:0]] = m_regs[ins[3:2]];
            m_regs[ins[3:2]] = tmp;
        end else if (!v && we) begin
            if (ws < 3'd4) m_regs[ws[1:0]] = wd;
            else if (ws == 3'd4) m_flags = wd[4:0];
        end
        exp_regs = {m_regs[3], m_regs[2], m_regs[1], m_regs[0]};
        @(posedge clk);
        #1;
        check(regs_o == exp_regs, req, "regs", regs_o, exp_regs);
        check(flags_o == m_flags, "R8", "flags", 128'(flags_o), 128'(m_flags));
        check(done == exp_done, exp_done ? "R2" : "R11", "done", 128'(done), 128'(exp_done));
        check(swapped == exp_sw, req, "swapped", 128'(swapped), 128'(exp_sw));
    endtask

    task automatic load(input logic [2:0] ws, input logic [31:0] wd);
        step(1'b0, '0, 1'b1, ws, wd, "R10");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_regs[i] = '0;
        m_flags = '0;
        void'($urandom(32'h5A17));
        rst_n = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        check(regs_o == '0 && flags_o == '0 && !done && !swapped, "R1", "reset state",
              {regs_o[122:0], flags_o}, '0);
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;

        // Every condition code against every flag pattern.
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 32; f++) begin
                load(3'd4, 32'(f));
                load(3'd0, 32'h1000_0000 + 32'(c * 64 + f));
                load(3'd1, 32'h2000_0000 + 32'(c * 64 + f));
                step(1'b1, mk(4'(c), 2'd1, 2'd0), 1'b0, '0, '0, cond_req(4'(c)));
            end
        end

        // Directed corners.
        load(3'd2, 32'hCAFE_0002);
        load(3'd3, 32'hBEEF_0003);
        step(1'b1, mk(4'he, 2'd2, 2'd2), 1'b0, '0, '0, "R7");
        step(1'b1, mk(4'he, 2'd2, 2'd3), 1'b0, '0, '0, "R7");
        step(1'b1, mk(4'hf, 2'd0, 2'd3), 1'b0, '0, '0, "R5");
        step(1'b1, 32'h7B01_00E1, 1'b0, '0, '0, "R9");
        step(1'b1, 32'h7B00_01E1, 1'b0, '0, '0, "R9");
        step(1'b1, 32'h3B00_00E1, 1'b0, '0, '0, "R9");
        step(1'b1, mk(4'h7, 2'd0, 2'd1), 1'b1, 3'd0, 32'h1234_5678, "R10");
        step(1'b1, 32'hFFFF_FFFF, 1'b1, 3'd4, 32'h1F, "R10");
        load(3'd5, 32'hFFFF_FFFF);
        load(3'd7, 32'hFFFF_FFFF);
        step(1'b0, mk(4'he, 2'd1, 2'd0), 1'b0, '0, '0, "R11");

        // Seeded random stream.
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            logic [31:0] ins;
            r = $urandom % 10;
            ins = mk(4'($urandom), 2'($urandom), 2'($urandom));
            if (r == 0) ins[15:8] = 8'($urandom | 1);
            if (r == 1) ins[31:16] = 16'($urandom);
            if (r < 6)
                step(1'b1, ins, 1'($urandom), 3'($urandom), $urandom,
                     (r < 2) ? "R9" : cond_req(ins[7:4]));
            else
                step(1'($urandom % 3 == 0), ins, 1'b1, 3'($urandom % 6), $urandom, "R10");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule